// File: doc/BRIEF.md
# Congestion-Driven Routing Mode Controller

This block sits beside the route computation stage of one mesh router and decides, at run time, whether packets are routed deterministically or adaptively. On every cycle it looks at the fill level of each neighbour-facing input buffer. It keeps a registered congestion flag with hysteresis: the flag sets when any buffer reaches an upper threshold, and it clears only once every buffer has dropped below a lower threshold. This keeps the routing policy from flipping back and forth while the load hovers near a single level.

The routing mode that the route computation unit sees is a second register. It copies the congestion flag only on cycles where the router reports that it is between packets. Because of this, all flits of one wormhole packet are routed under the same mode. The block also counts mode changes, and the count wraps.

The route computation unit supplies up to two minimal-path candidate output ports: one in the X dimension and one in the Y dimension. In deterministic mode the block always takes the X candidate when there is one, which gives dimension-ordered routing. In adaptive mode it compares the link load reported for each candidate and takes the lighter one. When the two loads are equal, the X candidate wins. The buffers and the routing function are outside this block.

Top module: `routing_mode_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `congested` is 0, `adaptive_mode` is 0 (deterministic) and `switch_cnt` is 0.
- R2: If `congested` is 0 and any port's occupancy field `buf_occ[p*OCC_W +: OCC_W]` is at or above HI_TH at a rising clock edge, `congested` is 1 after that edge. If every field is below HI_TH, it stays 0.
- R3: Once `congested` is 1, it stays 1 while any occupancy field is at or above LO_TH. It becomes 0 at the first edge where every field is below LO_TH.
- R4: At an edge where `pkt_boundary` is 1, `adaptive_mode` takes the value `congested` had before that edge (1 = adaptive, 0 = deterministic). At an edge where `pkt_boundary` is 0, `adaptive_mode` keeps its value.
- R5: `switch_cnt` increases by one at each edge where `adaptive_mode` changes, wraps modulo 2^CNT_W, and otherwise holds.
- R6: In deterministic mode, `sel_port` equals `cand_x_port` when `cand_x_vld` is 1, and otherwise equals `cand_y_port`. `sel_vld` is `cand_x_vld | cand_y_vld`. The output follows the inputs in the same cycle.
- R7: In adaptive mode with both candidates valid, the port whose load field `link_load[port*OCC_W +: OCC_W]` is strictly smaller is selected.
- R8: In adaptive mode with both candidates valid and equal loads, `cand_x_port` is selected.
- R9: In either mode, when exactly one candidate is valid, that candidate is selected. When neither is valid, `sel_vld` is 0 and `sel_port` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_occ | input | NPORT*OCC_W | Input buffer occupancy; port p in bits p*OCC_W +: OCC_W |
| link_load | input | NPORT*OCC_W | Load of the link behind each output port, same packing |
| pkt_boundary | input | 1 | 1 when no packet is in flight, so the mode may change |
| cand_x_vld | input | 1 | X-dimension candidate present |
| cand_x_port | input | PW | X-dimension candidate output port |
| cand_y_vld | input | 1 | Y-dimension candidate present |
| cand_y_port | input | PW | Y-dimension candidate output port |
| congested | output | 1 | Registered congestion flag with hysteresis |
| adaptive_mode | output | 1 | Current routing mode, 1 = adaptive |
| switch_cnt | output | CNT_W | Wrapping count of mode changes |
| sel_vld | output | 1 | A port was selected |
| sel_port | output | PW | Selected output port |

## Verification
There are three timings to check. `congested` responds one rising edge after an occupancy change. `adaptive_mode` and `switch_cnt` respond one edge after `congested` when `pkt_boundary` is high, so they are two edges behind an occupancy change. Port selection is combinational and is settled within the same cycle. The bench drives every input on a falling edge. It counts the rising edges to the result and samples the registered outputs on a later falling edge. Selection is checked one time step after its inputs are driven, with the mode held fixed. The hysteresis band, the boundary gating and the counter wrap are each checked at their edges: occupancy exactly at LO_TH and just below HI_TH, a congestion change while no boundary is reported, and a reduced counter width so the wrap is reached.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

   typedef enum logic {
      MODE_DET   = 1'b0,
      MODE_ADAPT = 1'b1
   } rmode_e;

endpackage

// File: rtl/rmc_cong_detect.sv
module rmc_cong_detect #(
   parameter int NPORT = 4,
   parameter int OCC_W = 4,
   parameter int HI_TH = 12,
   parameter int LO_TH = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NPORT*OCC_W-1:0] occ,
   output logic                   congested
);

   localparam logic [OCC_W-1:0] HI_V = OCC_W'(HI_TH);
   localparam logic [OCC_W-1:0] LO_V = OCC_W'(LO_TH);

   if (LO_TH < 1) begin : g_bad_lo
      $error("LO_TH must be at least 1");
   end
   if (LO_TH > HI_TH) begin : g_bad_order
      $error("LO_TH must not exceed HI_TH");
   end
   if (HI_TH > (2**OCC_W) - 1) begin : g_bad_hi
      $error("HI_TH does not fit in OCC_W bits");
   end

   logic [NPORT-1:0] at_hi;
   logic [NPORT-1:0] below_lo;
   logic             cong_q;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic [OCC_W-1:0] lvl;
      assign lvl         = occ[p*OCC_W +: OCC_W];
      assign at_hi[p]    = (lvl >= HI_V);
      assign below_lo[p] = (lvl < LO_V);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cong_q <= 1'b0;
      end else if (!cong_q && (|at_hi)) begin
         cong_q <= 1'b1;
      end else if (cong_q && (&below_lo)) begin
         cong_q <= 1'b0;
      end
   end

   assign congested = cong_q;

   // R2: a port at the upper threshold sets the flag on the next edge
   p_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cong_q && (|at_hi)) |=> cong_q);

   // R2: with no port at the upper threshold the flag stays clear
   p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cong_q && !(|at_hi)) |=> !cong_q);

   // R3: the flag holds while any port is still at or above the lower threshold
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cong_q && !(&below_lo)) |=> cong_q);

endmodule

// File: rtl/rmc_mode_latch.sv
module rmc_mode_latch
   import rmc_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             congested,
   input  logic             pkt_boundary,
   output rmode_e           mode,
   output logic [CNT_W-1:0] switch_cnt
);

   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   rmode_e           mode_q;
   logic [CNT_W-1:0] cnt_q;
   rmode_e           want;
   logic             flip;

   assign want = congested ? MODE_ADAPT : MODE_DET;
   assign flip = pkt_boundary && (want != mode_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_DET;
         cnt_q  <= '0;
      end else if (flip) begin
         mode_q <= want;
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign mode       = mode_q;
   assign switch_cnt = cnt_q;

   // R4: no boundary means no mode change
   p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_boundary |=> $stable(mode_q));

   // R4: at a boundary the mode copies the congestion flag
   p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_boundary |=> (logic'(mode_q) == $past(congested)));

   // R5: the counter advances by one on a change and holds otherwise
   p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_boundary && (congested != logic'(mode_q))) |=>
         (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   p_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(pkt_boundary && (congested != logic'(mode_q))) |=> $stable(cnt_q));

endmodule

// File: rtl/rmc_port_pick.sv
module rmc_port_pick
   import rmc_pkg::*;
#(
   parameter int NPORT = 4,
   parameter int OCC_W = 4,
   parameter int PW    = 2
) (
   input  rmode_e                 mode,
   input  logic [NPORT*OCC_W-1:0] link_load,
   input  logic                   cand_x_vld,
   input  logic [PW-1:0]          cand_x_port,
   input  logic                   cand_y_vld,
   input  logic [PW-1:0]          cand_y_port,
   output logic                   sel_vld,
   output logic [PW-1:0]          sel_port
);

   if (NPORT < 2) begin : g_bad_nport
      $error("NPORT must be at least 2");
   end
   if ((2**PW) < NPORT) begin : g_bad_pw
      $error("PW too narrow for NPORT");
   end

   logic [OCC_W-1:0] load_arr [NPORT];

   for (genvar p = 0; p < NPORT; p++) begin : g_load
      assign load_arr[p] = link_load[p*OCC_W +: OCC_W];
   end

   logic [OCC_W-1:0] load_x;
   logic [OCC_W-1:0] load_y;
   logic             y_lighter;

   assign load_x    = load_arr[cand_x_port];
   assign load_y    = load_arr[cand_y_port];
   assign y_lighter = (load_y < load_x);

   always_comb begin
      sel_vld  = cand_x_vld | cand_y_vld;
      sel_port = '0;
      if (cand_x_vld && cand_y_vld) begin
         if ((mode == MODE_ADAPT) && y_lighter) begin
            sel_port = cand_y_port;
         end else begin
            sel_port = cand_x_port;
         end
      end else if (cand_x_vld) begin
         sel_port = cand_x_port;
      end else if (cand_y_vld) begin
         sel_port = cand_y_port;
      end
   end

endmodule

// File: rtl/routing_mode_ctrl.sv
module routing_mode_ctrl
   import rmc_pkg::*;
#(
   parameter int NPORT = 4,
   parameter int OCC_W = 4,
   parameter int HI_TH = 12,
   parameter int LO_TH = 4,
   parameter int CNT_W = 8,
   parameter int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NPORT*OCC_W-1:0] buf_occ,
   input  logic [NPORT*OCC_W-1:0] link_load,
   input  logic                   pkt_boundary,
   input  logic                   cand_x_vld,
   input  logic [PW-1:0]          cand_x_port,
   input  logic                   cand_y_vld,
   input  logic [PW-1:0]          cand_y_port,
   output logic                   congested,
   output logic                   adaptive_mode,
   output logic [CNT_W-1:0]       switch_cnt,
   output logic                   sel_vld,
   output logic [PW-1:0]          sel_port
);

   rmode_e mode;

   rmc_cong_detect #(
      .NPORT (NPORT),
      .OCC_W (OCC_W),
      .HI_TH (HI_TH),
      .LO_TH (LO_TH)
   ) u_cong (
      .clk       (clk),
      .rst_n     (rst_n),
      .occ       (buf_occ),
      .congested (congested)
   );

   rmc_mode_latch #(
      .CNT_W (CNT_W)
   ) u_mode (
      .clk          (clk),
      .rst_n        (rst_n),
      .congested    (congested),
      .pkt_boundary (pkt_boundary),
      .mode         (mode),
      .switch_cnt   (switch_cnt)
   );

   rmc_port_pick #(
      .NPORT (NPORT),
      .OCC_W (OCC_W),
      .PW    (PW)
   ) u_pick (
      .mode        (mode),
      .link_load   (link_load),
      .cand_x_vld  (cand_x_vld),
      .cand_x_port (cand_x_port),
      .cand_y_vld  (cand_y_vld),
      .cand_y_port (cand_y_port),
      .sel_vld     (sel_vld),
      .sel_port    (sel_port)
   );

   assign adaptive_mode = (mode == MODE_ADAPT);

   // R6: deterministic mode takes the X candidate whenever it exists
   p_det_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!adaptive_mode && cand_x_vld) |-> (sel_port == cand_x_port));

   // R7: adaptive mode never picks the strictly heavier candidate
   p_light_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (adaptive_mode && cand_x_vld && cand_y_vld &&
       (link_load[cand_y_port*OCC_W +: OCC_W] < link_load[cand_x_port*OCC_W +: OCC_W]))
      |-> (sel_port == cand_y_port));

   // R8: equal loads favour the X candidate
   p_tie_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (adaptive_mode && cand_x_vld && cand_y_vld &&
       (link_load[cand_y_port*OCC_W +: OCC_W] == link_load[cand_x_port*OCC_W +: OCC_W]))
      |-> (sel_port == cand_x_port));

   // R9: no candidate means no selection
   p_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cand_x_vld && !cand_y_vld) |-> (!sel_vld && (sel_port == '0)));

   // R1: the first cycle after reset is in the reset state
   p_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (!congested && !adaptive_mode && (switch_cnt == '0)));

endmodule

// File: tb/routing_mode_ctrl_tb.sv
module routing_mode_ctrl_tb;

   localparam int NPORT = 4;
   localparam int OCC_W = 4;
   localparam int HI_TH = 12;
   localparam int LO_TH = 4;
   localparam int CNT_W = 3;
   localparam int PW    = 2;

   logic                   clk = 1'b0;
   logic                   rst_n;
   logic [NPORT*OCC_W-1:0] buf_occ;
   logic [NPORT*OCC_W-1:0] link_load;
   logic                   pkt_boundary;
   logic                   cand_x_vld;
   logic [PW-1:0]          cand_x_port;
   logic                   cand_y_vld;
   logic [PW-1:0]          cand_y_port;
   logic                   congested;
   logic                   adaptive_mode;
   logic [CNT_W-1:0]       switch_cnt;
   logic                   sel_vld;
   logic [PW-1:0]          sel_port;

   int checks = 0;
   int fails  = 0;
   int exp_cnt;

   // 100 MHz clock, 10 time units per period
   always #5 clk = ~clk;

   routing_mode_ctrl #(
      .NPORT (NPORT), .OCC_W (OCC_W), .HI_TH (HI_TH),
      .LO_TH (LO_TH), .CNT_W (CNT_W), .PW (PW)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .buf_occ (buf_occ), .link_load (link_load),
      .pkt_boundary (pkt_boundary),
      .cand_x_vld (cand_x_vld), .cand_x_port (cand_x_port),
      .cand_y_vld (cand_y_vld), .cand_y_port (cand_y_port),
      .congested (congested), .adaptive_mode (adaptive_mode),
      .switch_cnt (switch_cnt), .sel_vld (sel_vld), .sel_port (sel_port)
   );

   typedef struct packed {
      logic       xv;
      logic [1:0] xp;
      logic       yv;
      logic [1:0] yp;
      logic [15:0] ld;   // port3..port0 nibbles
      logic       dv;
      logic [1:0] dp;
      logic       av;
      logic [1:0] ap;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VT [NV] = '{
      '{1'b1, 2'd0, 1'b1, 2'd2, 16'h0305, 1'b1, 2'd0, 1'b1, 2'd2},  // y lighter
      '{1'b1, 2'd1, 1'b1, 2'd3, 16'h2070, 1'b1, 2'd1, 1'b1, 2'd3},  // y lighter
      '{1'b1, 2'd0, 1'b1, 2'd3, 16'h4004, 1'b1, 2'd0, 1'b1, 2'd0},  // tie
      '{1'b1, 2'd1, 1'b1, 2'd2, 16'h0910, 1'b1, 2'd1, 1'b1, 2'd1},  // x lighter
      '{1'b0, 2'd1, 1'b1, 2'd2, 16'h0F00, 1'b1, 2'd2, 1'b1, 2'd2},  // only y
      '{1'b1, 2'd0, 1'b0, 2'd3, 16'h000F, 1'b1, 2'd0, 1'b1, 2'd0},  // only x
      '{1'b0, 2'd2, 1'b0, 2'd1, 16'h1234, 1'b0, 2'd0, 1'b0, 2'd0}   // none
   };

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic occ_all(input logic [OCC_W-1:0] v);
      buf_occ = {NPORT{v}};
   endtask

   task automatic walk(input bit adapt);
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         cand_x_vld  = VT[i].xv;
         cand_x_port = VT[i].xp;
         cand_y_vld  = VT[i].yv;
         cand_y_port = VT[i].yp;
         link_load   = VT[i].ld;
         #1;
         if (!adapt) begin
            check($sformatf("R6 R9 det vec%0d vld", i), int'(sel_vld), int'(VT[i].dv));
            check($sformatf("R6 R9 det vec%0d port", i), int'(sel_port), int'(VT[i].dp));
         end else begin
            check($sformatf("R7 R8 R9 adapt vec%0d vld", i), int'(sel_vld), int'(VT[i].av));
            check($sformatf("R7 R8 R9 adapt vec%0d port", i), int'(sel_port), int'(VT[i].ap));
         end
      end
   endtask

   initial begin
      rst_n = 1'b0; occ_all('0); link_load = '0; pkt_boundary = 1'b0;
      cand_x_vld = 1'b0; cand_x_port = '0; cand_y_vld = 1'b0; cand_y_port = '0;
      tick(3);
      check("R1 congested in reset", int'(congested), 0);
      check("R1 mode in reset", int'(adaptive_mode), 0);
      check("R1 count in reset", int'(switch_cnt), 0);
      rst_n = 1'b1;
      tick(1);
      check("R1 congested after reset", int'(congested), 0);

      // R2: one below the upper threshold everywhere
      occ_all(4'd11);
      tick(3);
      check("R2 below upper threshold", int'(congested), 0);

      // R2: port 2 reaches the threshold, boundary held low
      buf_occ[2*OCC_W +: OCC_W] = 4'd12;
      tick(1);
      check("R2 flag sets after one edge", int'(congested), 1);
      tick(3);
      check("R4 no boundary, mode held", int'(adaptive_mode), 0);
      check("R5 no change, count held", int'(switch_cnt), 0);

      walk(1'b0);

      pkt_boundary = 1'b1;
      tick(1);
      check("R4 boundary enters adaptive", int'(adaptive_mode), 1);
      check("R5 count after first change", int'(switch_cnt), 1);
      pkt_boundary = 1'b0;

      // R3: exactly at the lower threshold keeps the flag
      occ_all(4'd4);
      tick(3);
      check("R3 at lower threshold holds", int'(congested), 1);

      walk(1'b1);

      occ_all(4'd3);
      tick(1);
      check("R3 clears below lower threshold", int'(congested), 0);
      check("R4 mode waits for boundary", int'(adaptive_mode), 1);
      pkt_boundary = 1'b1;
      tick(1);
      check("R4 boundary returns to deterministic", int'(adaptive_mode), 0);
      check("R5 count after second change", int'(switch_cnt), 2);

      // R5: wrap at 2^CNT_W
      exp_cnt = 2;
      for (int k = 0; k < 3; k++) begin
         occ_all(4'd13);
         tick(2);
         exp_cnt = (exp_cnt + 1) % (1 << CNT_W);
         check("R4 follows flag up", int'(adaptive_mode), 1);
         check("R5 count up step", int'(switch_cnt), exp_cnt);
         occ_all(4'd0);
         tick(2);
         exp_cnt = (exp_cnt + 1) % (1 << CNT_W);
         check("R4 follows flag down", int'(adaptive_mode), 0);
         check("R5 count down step", int'(switch_cnt), exp_cnt);
      end
      check("R5 count wrapped to zero", int'(switch_cnt), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog R1..all actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule